// File: doc/BRIEF.md
# FPU Mode Control Register Unit

This unit holds the floating-point register-mode bit (FR) of the processor, two configuration words (one fixed, one with a write mask) and the read-only FPU implementation word. The pipeline sends it floating-point control-register reads and writes. Each access carries three items: the control register number, the general register index of the instruction and the write data. The unit answers in the same cycle with read data, or with a reserved-instruction exception pulse when the access is not allowed.

Two control register numbers act as commands rather than as storage. A write to register 1 clears FR and a write to register 4 sets FR. Each acts only when the implementation word shows that user FR switching is present and the general register index is zero. It also needs the enable bit in the second configuration word. Register 25 is a compact view of the FP control/status word that the FPU datapath keeps outside this unit. A write to register 25 is passed back out as an update strobe. The unit pulses a mode-change output one cycle after FR changes or the second configuration word is written, so the pipeline can flush instructions fetched under the old mode.

Top module: `fpu_mode_ctl`

## Requirements
- R1: After reset, frMode is 0, cfg4Val is 32'h8000_0000, cfg5Val is 32'h0000_0004 (only the enable bit, bit 2, set), and modeChg, riExc and ccWrEn are 0.
- R2: A write with cfgWr=1 and cfgSel=1 updates only cfg5Val bits 30, 29, 27 and 2, taking them from cfgData, on the next clock edge. All other bits keep their old value.
- R3: A write with cfgWr=1 and cfgSel=0 never changes cfg4Val.
- R4: A read (cpAcc=1, cpWrite=0) of register 0 returns the FIR_VAL parameter. Bit 28 of FIR_VAL is the user-FR-present flag.
- R5: A read of register 1 returns FR in bit 0 and zeros above it when the present flag and cfg5Val bit 2 are both set. It raises riExc when the flag is set but bit 2 is clear. It returns zero with no exception when the flag is clear.
- R6: A write of register 1 clears FR and a write of register 4 sets FR, on the next clock edge. Both need the present flag set, gprIdx equal to 0 and cfg5Val bit 2 set.
- R7: A write of register 1 or 4 with gprIdx not zero, or with the present flag clear, leaves FR unchanged and raises no exception.
- R8: A write of register 1 or 4 with the present flag set and gprIdx zero, but cfg5Val bit 2 clear, raises riExc and leaves FR unchanged.
- R9: A read of register 25 returns fpCsrIn[31:25] in bits 7..1 and fpCsrIn[23] in bit 0, with zeros above.
- R10: A write of register 25 raises ccWrEn in the same cycle, with ccWrVal equal to wrData[7:0], only when wrData[31:8] is zero.
- R11: modeChg is high for exactly the one cycle after a clock edge at which FR changed value or cfg5Val was written. A set of FR when it is already set gives no pulse.
- R12: riExc is high only in a cycle with cpAcc=1. In that cycle no state changes, including a configuration write given in the same cycle.
- R13: A read of any other register number returns zero with no exception. A write of any other register number changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpAcc | input | 1 | Control-register access strobe |
| cpWrite | input | 1 | 1 = write access, 0 = read access |
| cpReg | input | 5 | Control register number |
| gprIdx | input | 5 | General register index of the instruction |
| wrData | input | 32 | Write data of the access |
| fpCsrIn | input | 32 | Current FP control/status word from the FPU |
| cfgWr | input | 1 | Configuration word write strobe |
| cfgSel | input | 1 | 0 = fixed word, 1 = masked word |
| cfgData | input | 32 | Configuration write data |
| rdData | output | 32 | Read data (zero when no read is in progress) |
| riExc | output | 1 | Reserved-instruction exception pulse |
| frMode | output | 1 | Current FR mode bit |
| modeChg | output | 1 | One-cycle pulse after a mode change |
| cfg4Val | output | 32 | Fixed configuration word |
| cfg5Val | output | 32 | Masked configuration word |
| ccWrEn | output | 1 | Strobe to update the FP condition view |
| ccWrVal | output | 8 | Data for that update |

## Verification
The assertions assume that the access inputs are sampled only while cpAcc is high, and that a configuration write may arrive in the same cycle as an access. They assume nothing about the mutual exclusion of these two inputs. The mode-pulse property compares FR with its value one edge earlier, so it depends on reset being held for at least one edge. The stimulus drives every input at the falling edge, keeps each access to a single cycle and holds reset for several cycles. It also deliberately puts a configuration write alongside a trapping access, to exercise the blocking rule.

// File: rtl/fpu_mode_pkg.sv
package fpu_mode_pkg;
  localparam int REG_AW   = 5;
  localparam int DATA_W   = 32;
  localparam int CC_W     = 8;

  localparam logic [REG_AW-1:0] REG_IMPL  = 5'd0;
  localparam logic [REG_AW-1:0] REG_FRCLR = 5'd1;
  localparam logic [REG_AW-1:0] REG_FRSET = 5'd4;
  localparam logic [REG_AW-1:0] REG_CCV   = 5'd25;

  localparam int IMPL_UFR_PRESENT_BIT = 28;
  localparam int CFG5_UFR_BIT         = 2;

  localparam logic [DATA_W-1:0] CFG4_RST   = 32'h8000_0000;
  localparam logic [DATA_W-1:0] CFG4_WMASK = 32'h0000_0000;
  localparam logic [DATA_W-1:0] CFG5_RST   = 32'h0000_0004;
  localparam logic [DATA_W-1:0] CFG5_WMASK = 32'h6800_0004;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_IMPL = 2'd1,
    RD_FR   = 2'd2,
    RD_CCV  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   frClr;
    logic   frSet;
    logic   cfg4Wr;
    logic   cfg5Wr;
    rdSel_e rdSel;
  } ctlStrobes_t;
endpackage

// File: rtl/fpu_mode_maskreg.sv
module fpu_mode_maskreg #(
  parameter int               W     = 32,
  parameter logic [W-1:0]     RST   = '0,
  parameter logic [W-1:0]     WMASK = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [W-1:0] wrVal,
  output logic [W-1:0] q
);
  // One flop per bit; read-only bits reload their own value.
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (WMASK[b]) begin : g_rw
      always_ff @(posedge clk) begin
        if (!rstN)     q[b] <= RST[b];
        else if (wrEn) q[b] <= wrVal[b];
      end
    end else begin : g_ro
      always_ff @(posedge clk) begin
        if (!rstN) q[b] <= RST[b];
        else       q[b] <= q[b];
      end
    end
  end
endmodule

// File: rtl/fpu_mode_ctl_decode.sv
module fpu_mode_ctl_decode
  import fpu_mode_pkg::*;
#(
  parameter logic [DATA_W-1:0] FIR_VAL = 32'h1070_0093
) (
  input  logic              cpAcc,
  input  logic              cpWrite,
  input  logic [REG_AW-1:0] cpReg,
  input  logic [REG_AW-1:0] gprIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cfgWr,
  input  logic              cfgSel,
  input  logic              ufrEn,
  output ctlStrobes_t       strb,
  output logic              riExc,
  output logic              ccWrEn
);
  localparam logic UFRP = FIR_VAL[IMPL_UFR_PRESENT_BIT];

  logic aliasOk;
  logic ccDataOk;
  logic unusedWrLow;

  assign aliasOk     = UFRP && (gprIdx == '0);
  assign ccDataOk    = (wrData[DATA_W-1:CC_W] == '0);
  assign unusedWrLow = ^wrData[CC_W-1:0];

  always_comb begin
    strb.frClr = 1'b0;
    strb.frSet = 1'b0;
    strb.rdSel = RD_ZERO;
    riExc      = 1'b0;
    ccWrEn     = 1'b0;
    if (cpAcc && !cpWrite) begin
      unique case (cpReg)
        REG_IMPL:  strb.rdSel = RD_IMPL;
        REG_FRCLR: begin
          if (UFRP) begin
            if (ufrEn) strb.rdSel = RD_FR;
            else       riExc      = 1'b1;
          end
        end
        REG_CCV:   strb.rdSel = RD_CCV;
        default:   strb.rdSel = RD_ZERO;
      endcase
    end else if (cpAcc && cpWrite) begin
      unique case (cpReg)
        REG_FRCLR, REG_FRSET: begin
          if (aliasOk) begin
            if (!ufrEn)                 riExc      = 1'b1;
            else if (cpReg == REG_FRSET) strb.frSet = 1'b1;
            else                         strb.frClr = 1'b1;
          end
        end
        REG_CCV: ccWrEn = ccDataOk;
        default: ;
      endcase
    end
    strb.cfg4Wr = cfgWr && !cfgSel && !riExc;
    strb.cfg5Wr = cfgWr &&  cfgSel && !riExc;
  end
endmodule

// File: rtl/fpu_mode_ctl_regs.sv
module fpu_mode_ctl_regs
  import fpu_mode_pkg::*;
#(
  parameter logic [DATA_W-1:0] FIR_VAL = 32'h1070_0093
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [DATA_W-1:0] cfgData,
  input  logic [DATA_W-1:0] fpCsrIn,
  output logic              frMode,
  output logic              ufrEn,
  output logic              modeChg,
  output logic [DATA_W-1:0] cfg4Val,
  output logic [DATA_W-1:0] cfg5Val,
  output logic [DATA_W-1:0] rdData
);
  logic frQ;
  logic frNext;
  logic mcQ;
  logic unusedCsr;

  assign unusedCsr = ^{fpCsrIn[24], fpCsrIn[22:0]};

  fpu_mode_maskreg #(.W(DATA_W), .RST(CFG4_RST), .WMASK(CFG4_WMASK)) cfg4_i (
    .clk(clk), .rstN(rstN), .wrEn(strb.cfg4Wr), .wrVal(cfgData), .q(cfg4Val)
  );

  fpu_mode_maskreg #(.W(DATA_W), .RST(CFG5_RST), .WMASK(CFG5_WMASK)) cfg5_i (
    .clk(clk), .rstN(rstN), .wrEn(strb.cfg5Wr), .wrVal(cfgData), .q(cfg5Val)
  );

  always_comb begin
    frNext = frQ;
    if (strb.frClr)      frNext = 1'b0;
    else if (strb.frSet) frNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frQ <= 1'b0;
      mcQ <= 1'b0;
    end else begin
      frQ <= frNext;
      mcQ <= (frNext != frQ) || strb.cfg5Wr;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_IMPL: rdData = FIR_VAL;
      RD_FR:   rdData = {{(DATA_W-1){1'b0}}, frQ};
      RD_CCV:  rdData = {{(DATA_W-CC_W){1'b0}}, fpCsrIn[31:25], fpCsrIn[23]};
      default: rdData = '0;
    endcase
  end

  assign frMode  = frQ;
  assign modeChg = mcQ;
  assign ufrEn   = cfg5Val[CFG5_UFR_BIT];
endmodule

// File: rtl/fpu_mode_ctl.sv
module fpu_mode_ctl
  import fpu_mode_pkg::*;
#(
  parameter logic [31:0] FIR_VAL = 32'h1070_0093
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpAcc,
  input  logic        cpWrite,
  input  logic [4:0]  cpReg,
  input  logic [4:0]  gprIdx,
  input  logic [31:0] wrData,
  input  logic [31:0] fpCsrIn,
  input  logic        cfgWr,
  input  logic        cfgSel,
  input  logic [31:0] cfgData,
  output logic [31:0] rdData,
  output logic        riExc,
  output logic        frMode,
  output logic        modeChg,
  output logic [31:0] cfg4Val,
  output logic [31:0] cfg5Val,
  output logic        ccWrEn,
  output logic [7:0]  ccWrVal
);
  ctlStrobes_t strb;
  logic        ufrEn;

  fpu_mode_ctl_decode #(.FIR_VAL(FIR_VAL)) decode_i (
    .cpAcc(cpAcc), .cpWrite(cpWrite), .cpReg(cpReg), .gprIdx(gprIdx),
    .wrData(wrData), .cfgWr(cfgWr), .cfgSel(cfgSel), .ufrEn(ufrEn),
    .strb(strb), .riExc(riExc), .ccWrEn(ccWrEn)
  );

  fpu_mode_ctl_regs #(.FIR_VAL(FIR_VAL)) regs_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgData(cfgData),
    .fpCsrIn(fpCsrIn), .frMode(frMode), .ufrEn(ufrEn), .modeChg(modeChg),
    .cfg4Val(cfg4Val), .cfg5Val(cfg5Val), .rdData(rdData)
  );

  assign ccWrVal = wrData[CC_W-1:0];
endmodule

// File: rtl/fpu_mode_ctl_chk.sv
module fpu_mode_ctl_chk
  import fpu_mode_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        cpAcc,
  input logic        cpWrite,
  input logic [4:0]  cpReg,
  input logic [4:0]  gprIdx,
  input logic [31:0] wrData,
  input logic        cfgWr,
  input logic        cfgSel,
  input logic [31:0] cfgData,
  input logic        riExc,
  input logic        frMode,
  input logic        modeChg,
  input logic [31:0] cfg4Val,
  input logic [31:0] cfg5Val,
  input logic        ccWrEn
);
  AST_EXC_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    riExc |-> cpAcc) else $error("riExc without access"); // R12

  AST_EXC_FREEZES_FR: assert property (@(posedge clk) disable iff (!rstN)
    riExc |=> frMode == $past(frMode)) else $error("FR moved on trap"); // R8

  AST_EXC_BLOCKS_CFG5: assert property (@(posedge clk) disable iff (!rstN)
    riExc |=> cfg5Val == $past(cfg5Val)) else $error("cfg5 moved on trap"); // R12

  AST_CFG4_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && !cfgSel) |=> cfg4Val == $past(cfg4Val)) else $error("cfg4 changed"); // R3

  AST_CFG5_RO_BITS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cfg5Val & ~CFG5_WMASK) == ($past(cfg5Val) & ~CFG5_WMASK))
    else $error("cfg5 read-only bit changed"); // R2

  AST_FR_CHANGE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (frMode != $past(frMode)) |-> modeChg) else $error("no pulse on FR change"); // R11

  AST_FR_ONLY_BY_ALIAS: assert property (@(posedge clk) disable iff (!rstN)
    !(cpAcc && cpWrite && gprIdx == 5'd0 && (cpReg == REG_FRCLR || cpReg == REG_FRSET))
    |=> frMode == $past(frMode)) else $error("FR changed without alias write"); // R7

  AST_CC_WR_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    ccWrEn |-> (cpAcc && cpWrite && cpReg == REG_CCV && wrData[31:8] == 24'd0))
    else $error("illegal condition-view write"); // R10
endmodule

bind fpu_mode_ctl fpu_mode_ctl_chk chk_i (.*);

// File: tb/fpu_mode_ctl_tb_top.sv
`timescale 1ns/1ps
module fpu_mode_ctl_tb_top;
  localparam logic [31:0] FIR_A = 32'h1070_0093;
  localparam logic [31:0] FIR_B = 32'h0070_0093;
  localparam logic [31:0] MASK5 = 32'h6800_0004;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic        cpAcc = 0, cpWrite = 0, cfgWr = 0, cfgSel = 0;
  logic [4:0]  cpReg = 0, gprIdx = 0;
  logic [31:0] wrData = 0, fpCsrIn = 0, cfgData = 0;

  logic [31:0] rdD [2];
  logic        riE [2];
  logic        frM [2];
  logic        mcO [2];
  logic [31:0] c4O [2];
  logic [31:0] c5O [2];
  logic        ccE [2];
  logic [7:0]  ccV [2];

  fpu_mode_ctl #(.FIR_VAL(FIR_A)) dut_i (
    .clk(clk), .rstN(rstN), .cpAcc(cpAcc), .cpWrite(cpWrite), .cpReg(cpReg),
    .gprIdx(gprIdx), .wrData(wrData), .fpCsrIn(fpCsrIn), .cfgWr(cfgWr),
    .cfgSel(cfgSel), .cfgData(cfgData), .rdData(rdD[0]), .riExc(riE[0]),
    .frMode(frM[0]), .modeChg(mcO[0]), .cfg4Val(c4O[0]), .cfg5Val(c5O[0]),
    .ccWrEn(ccE[0]), .ccWrVal(ccV[0])
  );

  fpu_mode_ctl #(.FIR_VAL(FIR_B)) dutNoUfr_i (
    .clk(clk), .rstN(rstN), .cpAcc(cpAcc), .cpWrite(cpWrite), .cpReg(cpReg),
    .gprIdx(gprIdx), .wrData(wrData), .fpCsrIn(fpCsrIn), .cfgWr(cfgWr),
    .cfgSel(cfgSel), .cfgData(cfgData), .rdData(rdD[1]), .riExc(riE[1]),
    .frMode(frM[1]), .modeChg(mcO[1]), .cfg4Val(c4O[1]), .cfg5Val(c5O[1]),
    .ccWrEn(ccE[1]), .ccWrVal(ccV[1])
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state per instance.
  bit          mFr [2];
  bit          mMc [2];
  logic [31:0] mC5 [2];
  logic [31:0] firOf [2];
  bit          present [2];

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic checkState(string tag);
    for (int k = 0; k < 2; k++) begin
      chk(tag, "frMode",  {31'd0, frM[k]}, {31'd0, mFr[k]});
      chk(tag, "modeChg", {31'd0, mcO[k]}, {31'd0, mMc[k]});
      chk(tag, "cfg4Val", c4O[k], 32'h8000_0000);
      chk(tag, "cfg5Val", c5O[k], mC5[k]);
    end
  endtask

  task automatic step(string tag, bit acc, bit wr, logic [4:0] rg, logic [4:0] gi,
                      logic [31:0] wd, bit cw, bit cs, logic [31:0] cd);
    bit          eExc [2];
    bit          nFr  [2];
    bit          c5w  [2];
    logic [31:0] eRd  [2];
    bit          eCc;
    @(negedge clk);
    cpAcc = acc; cpWrite = wr; cpReg = rg; gprIdx = gi; wrData = wd;
    cfgWr = cw; cfgSel = cs; cfgData = cd;
    #2;
    eCc = acc && wr && rg == 5'd25 && wd[31:8] == 24'd0;
    for (int k = 0; k < 2; k++) begin
      eExc[k] = 0; eRd[k] = 0; nFr[k] = mFr[k];
      if (acc && !wr) begin
        if (rg == 5'd0) eRd[k] = firOf[k];
        else if (rg == 5'd1 && present[k]) begin
          if (mC5[k][2]) eRd[k] = {31'd0, mFr[k]};
          else           eExc[k] = 1;
        end else if (rg == 5'd25) eRd[k] = {24'd0, fpCsrIn[31:25], fpCsrIn[23]};
      end
      if (acc && wr && (rg == 5'd1 || rg == 5'd4) && present[k] && gi == 5'd0) begin
        if (mC5[k][2]) nFr[k] = (rg == 5'd4);
        else           eExc[k] = 1;
      end
      c5w[k] = cw && cs && !eExc[k];
      chk(tag, "riExc",  {31'd0, riE[k]}, {31'd0, eExc[k]});
      chk(tag, "rdData", rdD[k], eRd[k]);
      chk(tag, "ccWrEn", {31'd0, ccE[k]}, {31'd0, eCc});
      if (eCc) chk(tag, "ccWrVal", {24'd0, ccV[k]}, {24'd0, wd[7:0]});
    end
    @(posedge clk);
    #2;
    for (int k = 0; k < 2; k++) begin
      mMc[k] = (nFr[k] != mFr[k]) || c5w[k];
      mFr[k] = nFr[k];
      if (c5w[k]) mC5[k] = (mC5[k] & ~MASK5) | (cd & MASK5);
    end
    checkState(tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    firOf[0] = FIR_A; firOf[1] = FIR_B;
    present[0] = 1;   present[1] = 0;
    for (int k = 0; k < 2; k++) begin
      mFr[k] = 0; mMc[k] = 0; mC5[k] = 32'h0000_0004;
    end
    repeat (4) @(posedge clk);
    #2;
    checkState("R1");
    for (int k = 0; k < 2; k++) begin
      chk("R1", "riExc",  {31'd0, riE[k]}, 32'd0);
      chk("R1", "ccWrEn", {31'd0, ccE[k]}, 32'd0);
    end
    @(negedge clk); rstN = 1;
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R4", 1, 0, 0, 0, 0, 0, 0, 0);
    step("R5", 1, 0, 1, 0, 0, 0, 0, 0);
    step("R6", 1, 1, 4, 0, 32'hDEAD_BEEF, 0, 0, 0);
    step("R11", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R5", 1, 0, 1, 9, 0, 0, 0, 0);
    step("R11", 1, 1, 4, 0, 0, 0, 0, 0);
    step("R7", 1, 1, 1, 3, 0, 0, 0, 0);
    step("R7", 1, 1, 1, 31, 0, 0, 0, 0);
    step("R6", 1, 1, 1, 0, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 1, 1, 32'hFFFF_FFFF);
    step("R2", 0, 0, 0, 0, 0, 1, 1, 32'h0000_0000);
    step("R5", 1, 0, 1, 0, 0, 0, 0, 0);
    step("R8", 1, 1, 4, 0, 0, 0, 0, 0);
    step("R8", 1, 1, 1, 0, 0, 0, 0, 0);
    step("R7", 1, 1, 4, 2, 0, 0, 0, 0);
    step("R12", 1, 1, 4, 0, 0, 1, 1, 32'h0000_0004);
    step("R12", 1, 0, 1, 0, 0, 1, 1, 32'h4000_0004);
    step("R3", 0, 0, 0, 0, 0, 1, 0, 32'hFFFF_FFFF);
    step("R3", 0, 0, 0, 0, 0, 1, 0, 32'h0000_0000);
    step("R2", 0, 0, 0, 0, 0, 1, 1, 32'h9000_0005);
    fpCsrIn = 32'hFE80_0000;
    step("R9", 1, 0, 25, 0, 0, 0, 0, 0);
    fpCsrIn = 32'h5300_0000;
    step("R9", 1, 0, 25, 0, 0, 0, 0, 0);
    fpCsrIn = 32'h017F_FFFF;
    step("R9", 1, 0, 25, 0, 0, 0, 0, 0);
    step("R10", 1, 1, 25, 0, 32'h0000_005A, 0, 0, 0);
    step("R10", 1, 1, 25, 0, 32'h0000_0100, 0, 0, 0);
    step("R10", 1, 1, 25, 0, 32'h8000_00FF, 0, 0, 0);
    step("R6", 1, 1, 4, 0, 0, 0, 0, 0);
    for (int r = 0; r < 32; r++) begin
      if (r == 0)                  step("R4", 1, 0, r[4:0], 0, 0, 0, 0, 0);
      else if (r == 1)             step("R5", 1, 0, r[4:0], 0, 0, 0, 0, 0);
      else if (r == 25)            step("R9", 1, 0, r[4:0], 0, 0, 0, 0, 0);
      else                         step("R13", 1, 0, r[4:0], 0, 0, 0, 0, 0);
    end
    step("R13", 1, 1, 2, 0, 32'hFFFF_FFFF, 0, 0, 0);
    step("R13", 1, 1, 0, 0, 32'hFFFF_FFFF, 0, 0, 0);
    step("R13", 1, 1, 31, 0, 32'h0000_0001, 0, 0, 0);
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule